// File: doc/BRIEF.md
# SPI Master Serializer with Self-Generated Fill Bytes

This block is the byte engine of an SPI master. Software, or any producer, queues bytes into a small transmit queue; the engine shifts each one out on MOSI while shifting a byte in from MISO. Each received byte goes into a small receive queue. An SPI master only receives while it transmits, so a long read needs a long run of dummy writes. The block can produce those dummy bytes by itself, which saves the producer from feeding it.

When the fill function is switched on and the transmit queue is empty, the engine starts a new byte on its own. The fill value is set by a configuration bit: it is either a copy of the most recent byte sent, or the constant 0xFF. Each byte the engine starts on its own is reported as a transmit underrun, because the queue had nothing to give. The configuration can only change while the engine is quiet. Once filling is switched off, the engine stops clocking and the receive queue keeps whatever it already holds.

The serial clock is made from the system clock by a programmable half-period count. The wire format is SPI mode 0, most significant bit first.

Top module: `spi_fill_serializer`

## Requirements
- R1: SCLK idles low and each SCLK level lasts exactly `div_half`+1 system clocks. MOSI changes only on a falling SCLK edge, or at the start of a byte while SCLK is low. MISO is sampled on the rising edge. Bytes go MSB first, 8 SCLK periods per byte.
- R2: Queued transmit bytes are sent in the order they were accepted. The byte received during each transfer is placed into the receive queue in the same order.
- R3: With filling off and the transmit queue empty, SCLK stays low, no transfer starts, and `tx_idle` is 1.
- R4: In repeat fill mode (`cfg_fill_token`=0), a fill byte equals the last byte put on the wire. That record resets to 0x00 and is updated by every byte sent, queued or filled.
- R5: In token fill mode (`cfg_fill_token`=1), a fill byte is 0xFF.
- R6: `err_underrun` pulses for one cycle for each byte the engine starts by itself. A byte taken from the queue never raises it. Queued data always wins over fill.
- R7: A write on `cfg_we` takes effect only when the transmit queue is empty and the engine is idle (`tx_idle`=1). A write at any other time is ignored.
- R8: A byte that completes while the receive queue is full is dropped and `err_overrun` pulses for one cycle. The queued bytes are unchanged.
- R9: Once filling is switched off, no further transfer starts without queued data, and the receive queue keeps its bytes.
- R10: Both queues hold 4 bytes. `tx_ready` is 0 when the transmit queue is full, and `rx_valid` is 1 while the receive queue holds data.
- R11: After reset the transmit queue is empty with `tx_ready`=1, `rx_valid`=0, `tx_idle`=1, SCLK is low, and no error pulses are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | 8 | SCLK half period minus one, in system clocks; keep stable while busy |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_auto | input | 1 | Fill enable value written by `cfg_we` |
| cfg_fill_token | input | 1 | Fill select written by `cfg_we`: 0 repeat last byte, 1 send 0xFF |
| tx_data | input | 8 | Byte offered to the transmit queue |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmit queue has space |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue is not empty |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_idle | output | 1 | Transmit queue empty and serializer idle |
| err_underrun | output | 1 | One-cycle pulse per self-started byte |
| err_overrun | output | 1 | One-cycle pulse per byte lost to a full receive queue |

## Verification
The bench first enables repeat fill straight after reset. A design that did not clear the last-byte record would then send junk instead of 0x00. It lets the receive queue fill during a long fill run: a wrong queue depth or a missing drop shows as the wrong retained bytes or the wrong overrun count. It also counts underruns against bytes sent, which exposes a design that flags queued bytes too or misses fill bytes. It tries to enable filling during a queued transfer; a design that accepts that write keeps clocking forever afterwards. It then switches fill off in the one-cycle gap between fill bytes, where a design with a racing start would send an extra byte. Random byte streams at several divider settings check bit order and SCLK timing against a slave model.

// File: rtl/spi_fill_pkg.sv
package spi_fill_pkg;
  typedef enum logic {
    FILL_REPEAT = 1'b0,
    FILL_TOKEN  = 1'b1
  } fill_sel_e;

  localparam logic [7:0] FILL_TOKEN_BYTE = 8'hFF;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         full, empty, push, pop;

  assign empty     = (wp == rp);
  assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push      = in_valid && !full;
  assign pop       = out_ready && !empty;
  assign out_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ((wp - rp) <= (AW+1)'(DEPTH))) else $error("queue occupancy above depth"); // R10
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div_half,
  input  logic            start,
  input  logic [DW-1:0]   tx_byte,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rx_byte,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso
);
  localparam int BW = $clog2(DW);

  logic [DIVW-1:0] div_cnt;
  logic [BW-1:0]   bit_cnt;
  logic [DW-1:0]   sh_tx, sh_rx;
  logic            sclk_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk_r  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sh_tx   <= tx_byte;
          div_cnt <= '0;
          bit_cnt <= '0;
          sclk_r  <= 1'b0;
        end
      end else if (div_cnt == div_half) begin
        div_cnt <= '0;
        sclk_r  <= !sclk_r;
        if (!sclk_r) begin
          sh_rx <= {sh_rx[DW-2:0], miso};
        end else if (bit_cnt == BW'(DW-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sh_tx   <= {sh_tx[DW-2:0], 1'b0};
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign sclk    = sclk_r;
  assign mosi    = sh_tx[DW-1];
  assign rx_byte = sh_rx;

  AST_SCLK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy |-> !sclk_r)) else $error("sclk high while idle"); // R1
  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk_r) |-> $stable(mosi))) else $error("mosi moved on rising sclk"); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (done |=> !done)) else $error("done longer than one cycle"); // R2
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import spi_fill_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_auto,
  input  logic          cfg_fill_token,
  input  logic [DW-1:0] txq_data,
  input  logic          txq_valid,
  output logic          tx_pop,
  input  logic          busy,
  input  logic          done,
  output logic          start,
  output logic [DW-1:0] start_byte,
  input  logic          rx_space,
  output logic          tx_idle,
  output logic          err_underrun,
  output logic          err_overrun
);
  logic          auto_en;
  fill_sel_e     fill_sel;
  logic [DW-1:0] last_tx;
  logic          gap_ok, cfg_ok;

  assign gap_ok  = !busy && !done;
  assign start   = gap_ok && (txq_valid || auto_en);
  assign tx_pop  = gap_ok && txq_valid;
  assign tx_idle = !busy && !txq_valid;
  assign cfg_ok  = tx_idle && !start;

  always_comb begin
    if (txq_valid)                 start_byte = txq_data;
    else if (fill_sel == FILL_TOKEN) start_byte = DW'(FILL_TOKEN_BYTE);
    else                           start_byte = last_tx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en      <= 1'b0;
      fill_sel     <= FILL_REPEAT;
      last_tx      <= '0;
      err_underrun <= 1'b0;
      err_overrun  <= 1'b0;
    end else begin
      if (cfg_we && cfg_ok) begin
        auto_en  <= cfg_auto;
        fill_sel <= fill_sel_e'(cfg_fill_token);
      end
      if (start) last_tx <= start_byte;
      err_underrun <= start && !txq_valid;
      err_overrun  <= done && !rx_space;
    end
  end

  AST_CFG_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(auto_en) |-> $past(!busy && !txq_valid))) else $error("fill mode changed while active"); // R7
  AST_UNDERRUN_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (err_underrun |-> $past(!txq_valid))) else $error("underrun with queued data"); // R6
  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    (err_overrun |-> $past(done && !rx_space))) else $error("overrun without full queue"); // R8
endmodule

// File: rtl/spi_fill_serializer.sv
module spi_fill_serializer #(
  parameter int DW    = 8,
  parameter int DIVW  = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div_half,
  input  logic            cfg_we,
  input  logic            cfg_auto,
  input  logic            cfg_fill_token,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            tx_idle,
  output logic            err_underrun,
  output logic            err_overrun
);
  logic [DW-1:0] txq_data, start_byte, rx_byte;
  logic          txq_valid, tx_pop, start, busy, done, rx_space;

  sfs_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .out_data(txq_data), .out_valid(txq_valid), .out_ready(tx_pop)
  );

  sfs_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .in_data(rx_byte), .in_valid(done), .in_ready(rx_space),
    .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready)
  );

  sfs_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_auto(cfg_auto), .cfg_fill_token(cfg_fill_token),
    .txq_data(txq_data), .txq_valid(txq_valid), .tx_pop(tx_pop),
    .busy(busy), .done(done), .start(start), .start_byte(start_byte),
    .rx_space(rx_space), .tx_idle(tx_idle),
    .err_underrun(err_underrun), .err_overrun(err_overrun)
  );

  sfs_shifter #(.DW(DW), .DIVW(DIVW)) u_shift (
    .clk(clk), .rst(rst), .div_half(div_half),
    .start(start), .tx_byte(start_byte),
    .busy(busy), .done(done), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );
endmodule

// File: tb/tb_spi_fill_serializer.sv
`timescale 1ns/1ps
module tb_spi_fill_serializer;
  logic       clk = 1'b0, rst = 1'b1;
  logic [7:0] div_half = 8'd1;
  logic       cfg_we = 1'b0, cfg_auto = 1'b0, cfg_fill_token = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       sclk, mosi, miso, tx_idle, err_underrun, err_overrun;

  spi_fill_serializer dut (
    .clk(clk), .rst(rst), .div_half(div_half),
    .cfg_we(cfg_we), .cfg_auto(cfg_auto), .cfg_fill_token(cfg_fill_token),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .tx_idle(tx_idle),
    .err_underrun(err_underrun), .err_overrun(err_overrun)
  );

  always #2 clk = !clk;

  int nchk = 0, nerr = 0;
  int mcnt = 0, rcnt = 0, urn = 0, orn = 0, hi_run = 0, per_bad = 0, bitc = 0;
  logic [7:0] mlog [0:511];
  logic [7:0] rlog [0:511];
  logic [7:0] m_sh = 8'h00, s_sh;
  bit   auto_on = 0;

  function automatic logic [7:0] sval(input int j);
    return 8'(j * 29) ^ 8'h5A;
  endfunction

  initial s_sh = sval(0);
  assign miso = s_sh[7];

  // slave model, mode 0
  always @(posedge sclk) begin
    m_sh = {m_sh[6:0], mosi};
    bitc = bitc + 1;
  end
  always @(negedge sclk) begin
    if (bitc == 8) begin
      mlog[mcnt] = m_sh;
      mcnt = mcnt + 1;
      bitc = 0;
      s_sh = sval(mcnt);
    end else begin
      s_sh = {s_sh[6:0], 1'b0};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (err_underrun) urn = urn + 1;
      if (err_overrun)  orn = orn + 1;
      if (rx_valid && rx_ready) begin
        rlog[rcnt] = rx_data;
        rcnt = rcnt + 1;
      end
      if (sclk) hi_run = hi_run + 1;
      else if (hi_run != 0) begin
        if (hi_run != int'(div_half) + 1) per_bad = per_bad + 1;
        hi_run = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push_tx(input logic [7:0] b);
    step();
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    step();
    tx_valid = 1'b0;
  endtask

  task automatic cfg_write(input bit a, input bit tok);
    if (auto_on) begin
      @(negedge clk);
      while (tx_idle) @(negedge clk);
    end
    @(negedge clk);
    while (!tx_idle) @(negedge clk);
    cfg_we = 1'b1; cfg_auto = a; cfg_fill_token = tok;
    step();
    cfg_we = 1'b0;
    auto_on = a;
  endtask

  task automatic quiet();
    int c = 0;
    while (c < 40) begin
      @(negedge clk);
      c = tx_idle ? c + 1 : 0;
    end
  endtask

  task automatic wait_bytes(input int target);
    while (mcnt < target) @(negedge clk);
  endtask

  task automatic fill_run(input bit tok, input int nbytes, input logic [7:0] expv, input string req);
    int b0, u0, bad;
    b0 = mcnt; u0 = urn; bad = 0;
    cfg_write(1'b1, tok);
    wait_bytes(b0 + nbytes);
    cfg_write(1'b0, 1'b0);
    quiet();
    for (int i = b0; i < mcnt; i++) if (mlog[i] !== expv) bad++;
    chk({req, " fill byte value"}, bad, 0);
    chk("R6 underrun per fill byte", urn - u0, mcnt - b0);
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n, m0, u0, b0, r0, bad, hi;
    logic [7:0] exp_b [0:15];
    void'($urandom(32'h5EED_1234));
    repeat (5) step();
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 tx_idle", tx_idle, 1);
    chk("R11 tx_ready", tx_ready, 1);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 sclk", sclk, 0);
    chk("R11 errors", err_underrun | err_overrun, 0);

    // R4 from reset (record 0x00), R8 overrun, R9 retention, R10 depth
    cfg_write(1'b1, 1'b0);
    wait_bytes(6);
    cfg_write(1'b0, 1'b0);
    quiet();
    n = mcnt;
    bad = 0;
    for (int i = 0; i < n; i++) if (mlog[i] !== 8'h00) bad++;
    chk("R4 reset fill value 00", bad, 0);
    chk("R6 underrun count", urn, n);
    chk("R8 overrun count", orn, n - 4);
    m0 = mcnt;
    repeat (200) @(negedge clk);
    chk("R9 no transfer after fill off", mcnt, m0);
    chk("R9 rx kept", rx_valid, 1);
    step(); rx_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 rx depth", rcnt, 4);
    bad = 0;
    for (int i = 0; i < 4; i++) if (rlog[i] !== sval(i)) bad++;
    chk("R8 retained bytes", bad, 0);

    // R2 / R10 queued stream at div 2
    step(); div_half = 8'd2;
    b0 = mcnt; r0 = rcnt; u0 = urn;
    exp_b[0] = 8'hA1; exp_b[1] = 8'hB2; exp_b[2] = 8'hC3; exp_b[3] = 8'hD4; exp_b[4] = 8'hE5;
    push_tx(exp_b[0]);
    @(negedge clk);
    while (tx_idle) @(negedge clk);
    for (int i = 1; i < 5; i++) push_tx(exp_b[i]);
    @(negedge clk);
    chk("R10 tx_ready low when full", tx_ready, 0);
    quiet();
    bad = 0;
    for (int i = 0; i < 5; i++) if (mlog[b0 + i] !== exp_b[i]) bad++;
    chk("R2 mosi order", bad + (mcnt - b0 - 5), 0);
    bad = 0;
    for (int i = 0; i < 5; i++) if (rlog[r0 + i] !== sval(b0 + i)) bad++;
    chk("R2 rx order", bad + (rcnt - r0 - 5), 0);
    chk("R6 no underrun for queued", urn - u0, 0);

    // R3 quiet state
    m0 = mcnt; hi = 0;
    repeat (100) begin @(negedge clk); if (sclk || !tx_idle) hi++; end
    chk("R3 idle line", hi + (mcnt - m0), 0);

    // R4 repeat of last byte, R5 token
    fill_run(1'b0, 3, 8'hE5, "R4");
    fill_run(1'b1, 3, 8'hFF, "R5");

    // R7 write while busy is ignored
    b0 = mcnt; u0 = urn;
    push_tx(8'h3C);
    @(negedge clk);
    while (tx_idle) @(negedge clk);
    cfg_we = 1'b1; cfg_auto = 1'b1; cfg_fill_token = 1'b0;
    step(); cfg_we = 1'b0; cfg_auto = 1'b0;
    quiet();
    repeat (100) @(negedge clk);
    chk("R7 ignored write bytes", mcnt - b0, 1);
    chk("R7 ignored write underrun", urn - u0, 0);

    // R1 / R2 random streams
    for (int r = 0; r < 5; r++) begin
      step(); div_half = 8'($urandom % 4);
      n = 1 + int'($urandom % 6);
      b0 = mcnt; r0 = rcnt;
      for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
      for (int i = 0; i < n; i++) push_tx(exp_b[i]);
      quiet();
      bad = 0;
      for (int i = 0; i < n; i++) begin
        if (mlog[b0 + i] !== exp_b[i]) bad++;
        if (rlog[r0 + i] !== sval(b0 + i)) bad++;
      end
      chk("R2 random stream", bad + (mcnt - b0 - n) + (rcnt - r0 - n), 0);
    end
    chk("R1 sclk half period", per_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule